// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is an 8-bit timer that counts down from a value loaded by software. The system clock passes through a 7-bit free-running prescaler, and one of eight power-of-two taps (divide by 1 up to divide by 128) supplies the decrement pulse. When a decrement takes the count to zero, a sticky interrupt flag is raised. The flag drives an interrupt request line only while the interrupt mask is clear.

Software reaches the timer through two byte-wide registers that share one address bit. Address 0 is the count register. Reading it returns the live count and does not disturb counting. Writing it reloads the count, and counting continues from the new value. Address 1 is the control register. It holds the flag, the mask, a prescaler-clear strobe and the ratio select. Reads are combinational on the address, and writes take effect on the next rising clock edge.

Top module: `dn_timer`

## Requirements
- R1: After reset, the control register reads 0x44: flag (bit 7) is 0, mask (bit 6) is 1, and ratio select (bits 2:0) is 100. The irq_o output is low, and the prescaler starts from zero.
- R2: The ratio select code c (bits 2:0 of the control register) makes the count decrement once every 2^c clocks. Code 000 decrements on every clock.
- R3: Reading address 0 returns the current count. Reads have no effect on the count or on its timing.
- R4: A write to address 0 loads the count from wdata_i. If a decrement falls in the same cycle, the load takes precedence.
- R5: The flag is set on the clock edge where a decrement takes the count from 1 to 0. The count keeps running, and the next decrement wraps it to 0xFF.
- R6: A control write with bit 7 = 0 clears the flag. A control write with bit 7 = 1 leaves the flag unchanged. Hardware never clears the flag, and a set in the same cycle as a clear wins.
- R7: A control write with bit 3 = 1 clears the prescaler, and no decrement happens on that edge. The first decrement after it comes exactly 2^c clocks after that write edge.
- R8: irq_o is high exactly when the flag is 1 and the mask is 0.
- R9: Control register bits 5:3 always read as 0, including bit 3 after a write of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 = count, 1 = control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
A prescaler that is out of step shows up at the count port as a decrement that lands one or more clocks early or late. The bench catches this on the first tick after a prescaler clear, because it samples the count on every clock. A wrong flag shows up in the same cycle on irq_o and on control bit 7. A count that is wrong at zero shows up one tick later as a missing wrap to 0xFF. A random sequence of reloads, control writes and idle cycles is checked each clock against a bench model of the count, flag, mask and prescaler phase. Directed sequences cover each ratio code, the flag write rules and the mask gating.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 3;
  // control register bit positions (software-visible)
  localparam int CTL_FLAG = 7;
  localparam int CTL_MASK = 6;
  localparam int CTL_PCLR = 3;
  localparam logic       ADDR_CNT  = 1'b0;
  localparam logic       ADDR_CTL  = 1'b1;
  localparam logic [SEL_W-1:0] SEL_RST = 3'b100;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] low_mask;

  always_comb begin
    for (int i = 0; i < PSC_W; i++) low_mask[i] = (i < int'(sel_i));
  end

  // tick when all bits below the selected tap are ones (carry into tap next)
  assign tick_o = (&(psc_q | ~low_mask)) && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    psc_q <= '0;
    else if (clr_i) psc_q <= '0;
    else            psc_q <= psc_q + 1'b1;
  end

  AST_PSC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (psc_q == '0)); // R7
  AST_DIV1_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0 && !clr_i) |-> tick_o); // R2
  AST_NO_TICK_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !tick_o); // R7
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign cnt_o      = cnt_q;
  assign zero_evt_o = tick_i && !load_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '1;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i)  cnt_q <= cnt_q - 1'b1;
  end

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q)); // R3
  AST_REACH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_evt_o |=> (cnt_q == '0)); // R5
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q == '0) |=> (cnt_q == '1)); // R5
endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             zero_evt_i,
  output logic             flag_o,
  output logic             mask_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             psc_clr_o
);
  logic             flag_q, mask_q;
  logic [SEL_W-1:0] sel_q;
  logic             flag_clr;

  assign flag_clr  = wr_i && !wdata_i[CTL_FLAG];
  assign psc_clr_o = wr_i && wdata_i[CTL_PCLR];
  assign flag_o    = flag_q;
  assign mask_o    = mask_q;
  assign sel_o     = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      mask_q <= 1'b1;
      sel_q  <= SEL_RST;
    end else begin
      // set beats clear so no zero crossing is lost
      if (zero_evt_i)    flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (wr_i) begin
        mask_q <= wdata_i[CTL_MASK];
        sel_q  <= wdata_i[SEL_W-1:0];
      end
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr) |=> flag_q); // R6
  AST_FLAG_SET_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(zero_evt_i)); // R5
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_evt_i |=> flag_q); // R6
endmodule

// File: rtl/dn_timer.sv
module dn_timer
  import tmr_pkg::*;
#(
  parameter int PSC_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  logic             wr_cnt, wr_ctl;
  logic             tick, zero_evt, psc_clr;
  logic             flag, mask;
  logic [SEL_W-1:0] sel;
  logic [REG_W-1:0] cnt;
  logic [REG_W-1:0] ctl_rd;

  assign wr_cnt = wr_i && (addr_i == ADDR_CNT);
  assign wr_ctl = wr_i && (addr_i == ADDR_CTL);

  tmr_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
    .clk_i, .rst_ni, .clr_i(psc_clr), .sel_i(sel), .tick_o(tick)
  );

  tmr_counter #(.CNT_W(REG_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(wr_cnt), .load_val_i(wdata_i),
    .cnt_o(cnt), .zero_evt_o(zero_evt)
  );

  tmr_ctrl_regs u_ctl (
    .clk_i, .rst_ni, .wr_i(wr_ctl), .wdata_i, .zero_evt_i(zero_evt),
    .flag_o(flag), .mask_o(mask), .sel_o(sel), .psc_clr_o(psc_clr)
  );

  always_comb begin
    ctl_rd           = '0;
    ctl_rd[CTL_FLAG] = flag;
    ctl_rd[CTL_MASK] = mask;
    ctl_rd[SEL_W-1:0] = sel;
  end

  assign rdata_o = (addr_i == ADDR_CNT) ? cnt : ctl_rd;
  assign irq_o   = flag && !mask;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> u_ctl.flag_q); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    u_ctl.mask_q |-> !irq_o); // R8
  AST_CTL_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CTL) |-> (rdata_o[5:3] == 3'b000)); // R9
endmodule

// File: tb/tb_dn_timer.sv
module tb_dn_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int total = 0;
  int bad   = 0;

  // bench model
  logic [6:0] m_psc;
  logic [7:0] m_cnt;
  logic       m_cnt_known;
  logic       m_flag, m_mask;
  logic [2:0] m_sel;

  always #5 clk_i = ~clk_i;

  dn_timer dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic m_tick(input logic clr);
    logic [6:0] lm;
    for (int i = 0; i < 7; i++) lm[i] = (i < int'(m_sel));
    return ((m_psc & lm) == lm) && !clr;
  endfunction

  task automatic step(input logic w, input logic a, input logic [7:0] d);
    logic clr, tk, zev;
    wr_i = w; addr_i = a; wdata_i = d;
    clr = w && a && d[3];
    tk  = m_tick(clr);
    zev = tk && !(w && !a) && (m_cnt == 8'd1) && m_cnt_known;
    @(posedge clk_i);
    m_psc = clr ? 7'd0 : m_psc + 7'd1;
    if (w && !a) begin m_cnt = d; m_cnt_known = 1'b1; end
    else if (tk) m_cnt = m_cnt - 8'd1;
    if (zev) m_flag = 1'b1;
    else if (w && a && !d[7]) m_flag = 1'b0;
    if (w && a) begin m_mask = d[6]; m_sel = d[2:0]; end
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic cmp_model(input string tag);
    logic [7:0] v;
    logic [7:0] exp_ctl;
    exp_ctl = {m_flag, m_mask, 3'b000, m_sel};
    peek(1'b1, v);
    check(v == exp_ctl, {tag, " ctl"}, v, exp_ctl);
    if (m_cnt_known) begin
      peek(1'b0, v);
      check(v == m_cnt, {tag, " cnt"}, v, m_cnt);
    end
    check(irq_o == (m_flag && !m_mask), "R8 irq", irq_o, m_flag && !m_mask);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'd20240611));
    m_psc = '0; m_cnt = '0; m_cnt_known = 1'b0;
    m_flag = 1'b0; m_mask = 1'b1; m_sel = 3'b100;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    peek(1'b1, v);
    check(v == 8'h44, "R1 ctl reset", v, 8'h44);
    check(irq_o == 1'b0, "R1 irq reset", irq_o, 0);

    // R2 / R7: each ratio, measured from a prescaler clear
    for (int c = 0; c < 8; c++) begin
      int n, n_exp;
      step(1'b1, 1'b1, {1'b0, 1'b1, 2'b00, 1'b1, 3'(c)});
      peek(1'b1, v);
      check(v[5:3] == 3'b000, "R9 clr bit reads 0", v, {1'b0, 1'b1, 3'b000, 3'(c)});
      step(1'b1, 1'b0, 8'h80);
      n_exp = (c == 0) ? 1 : (1 << c) - 1;
      n = 0;
      do begin
        step(1'b0, 1'b0, 8'h00);
        n++;
        peek(1'b0, v);
      end while (v == 8'h80 && n < 300);
      check(n == n_exp, "R2 R7 first decrement delay", n, n_exp);
      check(v == 8'h7F, "R2 one decrement", v, 8'h7F);
      // R2 steady period: next decrement 2^c clocks later
      n = 0;
      do begin
        step(1'b0, 1'b0, 8'h00);
        n++;
        peek(1'b0, v);
      end while (v == 8'h7F && n < 300);
      check(n == (1 << c), "R2 period", n, 1 << c);
    end

    // R5 zero crossing and wrap, ratio 1, unmasked
    step(1'b1, 1'b1, 8'h08);
    step(1'b1, 1'b0, 8'h02);
    step(1'b0, 1'b0, 8'h00);
    peek(1'b0, v);
    check(v == 8'h01, "R5 count 1", v, 8'h01);
    check(irq_o == 1'b0, "R8 no irq before zero", irq_o, 0);
    step(1'b0, 1'b0, 8'h00);
    peek(1'b0, v);
    check(v == 8'h00, "R5 count 0", v, 8'h00);
    peek(1'b1, v);
    check(v[7] == 1'b1, "R5 flag set", v, 8'h80);
    check(irq_o == 1'b1, "R8 irq unmasked", irq_o, 1);
    step(1'b0, 1'b0, 8'h00);
    peek(1'b0, v);
    check(v == 8'hFF, "R5 wrap", v, 8'hFF);

    // R6 write 1 keeps flag, write 0 clears; hardware keeps it
    step(1'b1, 1'b1, 8'h80);
    peek(1'b1, v);
    check(v == 8'h80, "R6 write1 no effect", v, 8'h80);
    repeat (5) step(1'b0, 1'b0, 8'h00);
    peek(1'b1, v);
    check(v[7] == 1'b1, "R6 flag sticky", v, 8'h80);
    step(1'b1, 1'b1, 8'h07);
    peek(1'b1, v);
    check(v == 8'h07, "R6 write0 clears", v, 8'h07);

    // R4 load beats tick (ratio 1 ticks every clock)
    step(1'b1, 1'b1, 8'h00);
    step(1'b1, 1'b0, 8'h55);
    peek(1'b0, v);
    check(v == 8'h55, "R4 load value", v, 8'h55);
    // R3 repeated reads do not disturb
    peek(1'b0, v); peek(1'b0, v);
    step(1'b0, 1'b0, 8'h00);
    peek(1'b0, v);
    check(v == 8'h54, "R3 read no disturb", v, 8'h54);

    // R8 mask gating with flag set
    step(1'b1, 1'b0, 8'h01);
    step(1'b0, 1'b0, 8'h00);
    check(irq_o == 1'b1, "R8 irq flag&!mask", irq_o, 1);
    step(1'b1, 1'b1, 8'hC0);
    peek(1'b1, v);
    check(v == 8'hC0, "R8 ctl masked", v, 8'hC0);
    check(irq_o == 1'b0, "R8 irq masked", irq_o, 0);
    step(1'b1, 1'b1, 8'hFF);
    peek(1'b1, v);
    check(v[5:3] == 3'b000, "R9 spare bits", v, 8'hC7);
    cmp_model("R1 sync");

    // random phase against model
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 12)      step(1'b1, 1'b0, 8'($urandom));
      else if (r < 22) step(1'b1, 1'b1, 8'($urandom) & 8'hCB);
      else             step(1'b0, 1'($urandom), 8'($urandom));
      cmp_model("R3 R5 R6 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule